// File: doc/BRIEF.md
# Processor Startup IPI Sequencer

This block sits beside one core's interrupt request tracker and reacts to each delivered interprocessor command. A command arrives as a one-cycle strobe carrying a 3-bit delivery mode, an 8-bit vector and a flag that says whether the sending core is this same core. Ordinary interrupts (fixed or lowest-priority) are handed straight to the request tracker. When the tracker reports that the interrupt is newly pending and the command came from another core, the block pulses a kick output so that the core is pulled out of guest execution.

Wake-up commands drive a three-state handshake. The core starts out waiting for a reset-style wake-up (INIT). An INIT moves it to waiting for the startup message. A startup message received in that state loads the core's initial code segment and instruction pointer from the vector and enables the core to run. Repeated or out-of-order wake-up messages are dropped without complaint, so the common INIT, INIT, startup pattern works. Delivery modes that this core cannot take report an error pulse.

Top module: `startup_ipi_seq`

## Requirements
- R1: After reset the sequence state is 0 (waiting for INIT), run-enable is low, and the selector, base, limit and instruction-pointer outputs are all zero.
- R2: A delivery with mode 5 (INIT) while the state is 0 sets the state to 1 (waiting for startup) on the next clock edge.
- R3: A mode 5 delivery while the state is 1 or 2 leaves the state and all start-context outputs unchanged and raises no error.
- R4: A mode 6 (startup) delivery while the state is 0 or 2 leaves the state, run-enable and start-context outputs unchanged and raises no error.
- R5: A mode 6 delivery while the state is 1 sets, on the next edge, selector = vector shifted left by 8, base = vector shifted left by 12, limit = 0xFFFF, instruction pointer = 0, run-enable high and state 2 (started).
- R6: Modes 2, 3, 4 and 7 pulse the error output during the strobe cycle and change no state.
- R7: Modes 0 (fixed) and 1 (lowest priority) pulse the tracker request output during the strobe cycle with the tracker vector equal to the delivered vector; no other mode pulses it.
- R8: The kick output pulses during a mode 0 or 1 strobe exactly when the tracker reports the interrupt as newly pending and the sender flag is low.
- R9: Once run-enable is high it and the start-context outputs hold their values until reset, whatever is delivered.
- R10: The error and kick outputs are low in every cycle without a delivery strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dlv_valid | input | 1 | One-cycle delivery strobe |
| dlv_mode | input | 3 | Delivery mode code |
| dlv_vector | input | 8 | Delivered vector |
| dlv_from_self | input | 1 | High when the sender is this core |
| trk_new | input | 1 | Tracker reports the forwarded interrupt as newly pending |
| trk_req | output | 1 | Pulse forwarding an interrupt to the tracker |
| trk_vector | output | 8 | Vector forwarded to the tracker |
| kick | output | 1 | Pulse forcing the core to notice a new interrupt |
| err_unsup | output | 1 | Pulse for an unsupported delivery mode |
| seq_state | output | 2 | Handshake state: 0 wait INIT, 1 wait startup, 2 started |
| run_en | output | 1 | Core allowed to run |
| cs_sel | output | 16 | Initial code segment selector |
| cs_base | output | 20 | Initial code segment base |
| cs_limit | output | 16 | Initial code segment limit |
| start_ip | output | 16 | Initial instruction pointer |

## Verification
The bench walks the handshake through a duplicated INIT and a startup message sent too early and too late: a sequencer that faulted on the second INIT would flag an error, and one that honoured a premature startup message would start the core with a stale vector. A second startup message after the core is running is aimed at designs that reload the context, which would silently move the entry point. Vectors 0x00 and 0xFF probe the shift arithmetic, where a truncated base or a swapped shift would show up in the top bits, and the sender flag is toggled with the tracker's new-pending input to catch a kick sent to the sender itself or for a coalesced interrupt.

// File: rtl/startup_ipi_pkg.sv
package startup_ipi_pkg;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSVD   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_EXTERN = 3'd7
  } dlv_mode_e;

  typedef enum logic [1:0] {
    SQ_WAIT_INIT  = 2'd0,
    SQ_WAIT_START = 2'd1,
    SQ_RUNNING    = 2'd2
  } seq_state_e;

endpackage

// File: rtl/sipi_mode_decode.sv
module sipi_mode_decode
  import startup_ipi_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] mode,
  output logic       is_irq,
  output logic       is_init,
  output logic       is_start,
  output logic       is_unsup
);

  always_comb begin
    is_irq   = 1'b0;
    is_init  = 1'b0;
    is_start = 1'b0;
    is_unsup = 1'b0;
    if (valid) begin
      unique case (dlv_mode_e'(mode))
        DM_FIXED, DM_LOWEST:            is_irq   = 1'b1;
        DM_INIT:                        is_init  = 1'b1;
        DM_START:                       is_start = 1'b1;
        DM_SMI, DM_RSVD, DM_NMI, DM_EXTERN: is_unsup = 1'b1;
        default:                        is_unsup = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/sipi_seq_fsm.sv
module sipi_seq_fsm
  import startup_ipi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_init,
  input  logic       is_start,
  output logic [1:0] state,
  output logic       load_ctx,
  output logic       run_en
);

  seq_state_e state_q, state_d;
  logic       run_q, run_d;

  always_comb begin
    state_d  = state_q;
    run_d    = run_q;
    load_ctx = 1'b0;
    unique case (state_q)
      SQ_WAIT_INIT:  if (is_init) state_d = SQ_WAIT_START;
      SQ_WAIT_START: if (is_start) begin
        state_d  = SQ_RUNNING;
        run_d    = 1'b1;
        load_ctx = 1'b1;
      end
      SQ_RUNNING:    state_d = SQ_RUNNING;
      default:       state_d = SQ_WAIT_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_WAIT_INIT;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
    end
  end

  assign state  = state_q;
  assign run_en = run_q;

  assert_init_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_init && state_q == SQ_WAIT_INIT) |=> (state_q == SQ_WAIT_START));

  assert_late_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_start && state_q != SQ_WAIT_START) |=> $stable(state_q));

  assert_init_repeat_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_init && state_q != SQ_WAIT_INIT) |=> $stable(state_q));

  assert_run_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);

endmodule

// File: rtl/sipi_ctx_regs.sv
module sipi_ctx_regs #(
  parameter int VEC_W   = 8,
  parameter int LIMIT_W = 16,
  parameter int IP_W    = 16,
  localparam int SEL_W  = VEC_W + 8,
  localparam int BASE_W = VEC_W + 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               locked,
  input  logic [VEC_W-1:0]   vector,
  output logic [SEL_W-1:0]   sel,
  output logic [BASE_W-1:0]  base,
  output logic [LIMIT_W-1:0] limit,
  output logic [IP_W-1:0]    ip
);

  logic [SEL_W-1:0]   sel_q,   sel_d;
  logic [BASE_W-1:0]  base_q,  base_d;
  logic [LIMIT_W-1:0] limit_q, limit_d;
  logic [IP_W-1:0]    ip_q,    ip_d;

  always_comb begin
    sel_d   = {vector, 8'h00};
    base_d  = {vector, 12'h000};
    limit_d = '1;
    ip_d    = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      base_q  <= '0;
      limit_q <= '0;
      ip_q    <= '0;
    end else if (load) begin
      sel_q   <= sel_d;
      base_q  <= base_d;
      limit_q <= limit_d;
      ip_q    <= ip_d;
    end
  end

  assign sel   = sel_q;
  assign base  = base_q;
  assign limit = limit_q;
  assign ip    = ip_q;

  assert_ctx_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(sel_q) && $stable(base_q) && $stable(limit_q) && $stable(ip_q)));

  assert_sel_base_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sel_q[SEL_W-1:8] == base_q[BASE_W-1:12]));

endmodule

// File: rtl/startup_ipi_seq.sv
module startup_ipi_seq
  import startup_ipi_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int LIMIT_W = 16,
  parameter int IP_W    = 16,
  localparam int SEL_W  = VEC_W + 8,
  localparam int BASE_W = VEC_W + 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dlv_valid,
  input  logic [2:0]         dlv_mode,
  input  logic [VEC_W-1:0]   dlv_vector,
  input  logic               dlv_from_self,
  input  logic               trk_new,
  output logic               trk_req,
  output logic [VEC_W-1:0]   trk_vector,
  output logic               kick,
  output logic               err_unsup,
  output logic [1:0]         seq_state,
  output logic               run_en,
  output logic [SEL_W-1:0]   cs_sel,
  output logic [BASE_W-1:0]  cs_base,
  output logic [LIMIT_W-1:0] cs_limit,
  output logic [IP_W-1:0]    start_ip
);

  logic is_irq, is_init, is_start, is_unsup;
  logic load_ctx;

  sipi_mode_decode u_decode (
    .valid    (dlv_valid),
    .mode     (dlv_mode),
    .is_irq   (is_irq),
    .is_init  (is_init),
    .is_start (is_start),
    .is_unsup (is_unsup)
  );

  sipi_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_init  (is_init),
    .is_start (is_start),
    .state    (seq_state),
    .load_ctx (load_ctx),
    .run_en   (run_en)
  );

  sipi_ctx_regs #(
    .VEC_W   (VEC_W),
    .LIMIT_W (LIMIT_W),
    .IP_W    (IP_W)
  ) u_ctx (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_ctx),
    .locked (run_en),
    .vector (dlv_vector),
    .sel    (cs_sel),
    .base   (cs_base),
    .limit  (cs_limit),
    .ip     (start_ip)
  );

  assign trk_req    = is_irq;
  assign trk_vector = dlv_vector;
  assign kick       = is_irq & trk_new & ~dlv_from_self;
  assign err_unsup  = is_unsup;

  assert_kick_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> trk_req);

  assert_err_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_unsup |-> (!trk_req && !kick));

  assert_pulse_on_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_unsup || kick) |-> dlv_valid);

  assert_err_no_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_unsup |=> $stable(seq_state));

endmodule

// File: tb/startup_ipi_seq_tb.sv
module startup_ipi_seq_tb;

  localparam time CYC = 4ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dlv_valid;
  logic [2:0]  dlv_mode;
  logic [7:0]  dlv_vector;
  logic        dlv_from_self;
  logic        trk_new;
  logic        trk_req;
  logic [7:0]  trk_vector;
  logic        kick;
  logic        err_unsup;
  logic [1:0]  seq_state;
  logic        run_en;
  logic [15:0] cs_sel;
  logic [19:0] cs_base;
  logic [15:0] cs_limit;
  logic [15:0] start_ip;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CYC/2) clk = ~clk;

  startup_ipi_seq u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .dlv_valid     (dlv_valid),
    .dlv_mode      (dlv_mode),
    .dlv_vector    (dlv_vector),
    .dlv_from_self (dlv_from_self),
    .trk_new       (trk_new),
    .trk_req       (trk_req),
    .trk_vector    (trk_vector),
    .kick          (kick),
    .err_unsup     (err_unsup),
    .seq_state     (seq_state),
    .run_en        (run_en),
    .cs_sel        (cs_sel),
    .cs_base       (cs_base),
    .cs_limit      (cs_limit),
    .start_ip      (start_ip)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // mode[17:15] vec[14:7] self[6] new[5] state[4:3] err[2] kick[1] req[0]
  localparam int NV = 13;
  localparam logic [17:0] VEC_TBL [NV] = '{
    {3'd0, 8'h40, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1}, // R7 R8 fixed, new, other sender
    {3'd1, 8'h41, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1}, // R8 lowest from self: no kick
    {3'd0, 8'h42, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1}, // R8 coalesced: no kick
    {3'd6, 8'h12, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0}, // R4 early startup ignored
    {3'd4, 8'h20, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0}, // R6 NMI
    {3'd5, 8'h00, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0}, // R2 INIT
    {3'd5, 8'h00, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0}, // R3 second INIT
    {3'd2, 8'h00, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0}, // R6 SMI
    {3'd6, 8'h9A, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0}, // R5 startup
    {3'd6, 8'h33, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0}, // R4 late startup ignored
    {3'd5, 8'h00, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0}, // R3 INIT while started
    {3'd7, 8'h00, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0}, // R6 external
    {3'd3, 8'h00, 1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0}  // R6 reserved
  };

  task automatic idle_inputs();
    dlv_valid = 1'b0; dlv_mode = 3'd0; dlv_vector = 8'h00;
    dlv_from_self = 1'b0; trk_new = 1'b0;
  endtask

  // drive at negedge, sample pulses mid-low-phase, return after next negedge
  task automatic deliver(input logic [2:0] m, input logic [7:0] v,
                         input logic s, input logic n,
                         output logic e, output logic k, output logic r,
                         output logic [7:0] tv);
    dlv_valid = 1'b1; dlv_mode = m; dlv_vector = v;
    dlv_from_self = s; trk_new = n;
    #1;
    e = err_unsup; k = kick; r = trk_req; tv = trk_vector;
    @(negedge clk);
    idle_inputs();
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
  endtask

  task automatic check_reset_state(input string tag);
    chk("R1", {tag, " state"}, 32'(seq_state), 32'd0);
    chk("R1", {tag, " run_en"}, 32'(run_en), 32'd0);
    chk("R1", {tag, " sel"}, 32'(cs_sel), 32'd0);
    chk("R1", {tag, " base"}, 32'(cs_base), 32'd0);
    chk("R1", {tag, " limit"}, 32'(cs_limit), 32'd0);
    chk("R1", {tag, " ip"}, 32'(start_ip), 32'd0);
  endtask

  initial begin
    #(CYC * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic e, k, r;
    logic [7:0] tv;
    do_reset();
    check_reset_state("reset");

    for (int i = 0; i < NV; i++) begin
      logic [17:0] t;
      t = VEC_TBL[i];
      deliver(t[17:15], t[14:7], t[6], t[5], e, k, r, tv);
      chk("R6", $sformatf("row%0d err", i), 32'(e), 32'(t[2]));
      chk("R8", $sformatf("row%0d kick", i), 32'(k), 32'(t[1]));
      chk("R7", $sformatf("row%0d trk_req", i), 32'(r), 32'(t[0]));
      if (t[0]) chk("R7", $sformatf("row%0d trk_vector", i), 32'(tv), 32'(t[14:7]));
      chk("R2", $sformatf("row%0d state", i), 32'(seq_state), 32'(t[4:3]));
      chk("R10", $sformatf("row%0d idle err", i), 32'(err_unsup), 32'd0);
      chk("R10", $sformatf("row%0d idle kick", i), 32'(kick), 32'd0);
      if (i == 3) begin
        chk("R4", "early startup run_en", 32'(run_en), 32'd0);
        chk("R4", "early startup sel", 32'(cs_sel), 32'd0);
      end
      if (i == 6) chk("R3", "second INIT sel", 32'(cs_sel), 32'd0);
    end

    // R5 and R9: context loaded from 0x9A, not from the later 0x33
    chk("R5", "sel", 32'(cs_sel), 32'h9A00);
    chk("R5", "base", 32'(cs_base), 32'h9A000);
    chk("R5", "limit", 32'(cs_limit), 32'hFFFF);
    chk("R5", "ip", 32'(start_ip), 32'h0);
    chk("R9", "run_en held", 32'(run_en), 32'd1);
    repeat (5) @(negedge clk);
    #1;
    chk("R9", "sel held after idle", 32'(cs_sel), 32'h9A00);
    chk("R9", "run_en held after idle", 32'(run_en), 32'd1);

    // reset while running
    do_reset();
    check_reset_state("reset while running");

    // boundary vector 0xFF
    deliver(3'd5, 8'h00, 1'b0, 1'b0, e, k, r, tv);
    chk("R2", "INIT after reset", 32'(seq_state), 32'd1);
    deliver(3'd6, 8'hFF, 1'b0, 1'b0, e, k, r, tv);
    chk("R5", "sel 0xFF", 32'(cs_sel), 32'hFF00);
    chk("R5", "base 0xFF", 32'(cs_base), 32'hFF000);
    chk("R5", "state 0xFF", 32'(seq_state), 32'd2);
    deliver(3'd0, 8'h55, 1'b0, 1'b1, e, k, r, tv);
    chk("R8", "kick while running", 32'(k), 32'd1);
    chk("R9", "sel after fixed irq", 32'(cs_sel), 32'hFF00);

    // boundary vector 0x00: context zero yet run enabled
    do_reset();
    deliver(3'd5, 8'h00, 1'b0, 1'b0, e, k, r, tv);
    deliver(3'd6, 8'h00, 1'b0, 1'b0, e, k, r, tv);
    chk("R5", "run_en vec0", 32'(run_en), 32'd1);
    chk("R5", "limit vec0", 32'(cs_limit), 32'hFFFF);
    chk("R5", "base vec0", 32'(cs_base), 32'h0);
    chk("R5", "state vec0", 32'(seq_state), 32'd2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

endmodule